// File: doc/BRIEF.md
# Frame-Synchronised Symbol Map Updater

The block collects tile update commands for a character-cell display and writes them into the symbol map RAM only while vertical sync is high, so the map that the pixel path reads stays fixed for a whole frame. The screen is 640x480 pixels tiled with 32x32 symbols. This gives 15 tile rows by 20 tile columns, or 300 map entries of 14 bits. Each map entry holds the base address of a symbol image in external memory, or zero for an empty tile.

Commands arrive on a valid/ready stream and wait in a 300-deep queue. The back-pressure rule is simple: `cmd_ready` is low exactly when the queue is full. A command moves only in a cycle where both `cmd_valid` and `cmd_ready` are high, and the producer must hold a command until that happens. The RAM write port has no back-pressure. While `vsync` is high, one command leaves the queue per clock. Each one becomes a single map write, or is dropped if its tile lies off screen. When vsync falls after at least one map write, a one-cycle pulse tells the downstream read manager that the map has changed.

Top module: `symmap_updater`

## Requirements
- R1: After reset, `map_we` and `map_updated` are 0, `fifo_empty` is 1, `fifo_full` is 0, `fifo_used` is 0 and `cmd_ready` is 1.
- R2: `cmd_ready` equals the inverse of `fifo_full`. A command is accepted only when `cmd_valid` and `cmd_ready` are both high. A command offered while the queue is full is not stored.
- R3: `fifo_used` counts the queued commands (0 to 300). `fifo_empty` is high at 0 and `fifo_full` is high at 300. A push and a pop in the same cycle leave the count unchanged.
- R4: While `vsync` is low, no command leaves the queue and `map_we` stays low.
- R5: In each clock where `vsync` is high and the queue is not empty, the oldest command is removed. Its map write appears on the port in the next cycle. Commands are applied in arrival order.
- R6: The command word has the type in bit 23, the symbol address in bits 22:9, the row x in bits 8:5 and the column y in bits 4:0. The write address is 20*x + y.
- R7: When type is 1 (add), `map_data` is the 14-bit symbol address. When type is 0 (remove), `map_data` is zero.
- R8: A command with x > 14 or y > 19 is removed from the queue but produces no map write.
- R9: `map_updated` pulses for exactly one cycle, one cycle after the clock where `vsync` is first seen low following a high phase. It pulses only if at least one map write came from that high phase.
- R10: Commands still queued when `vsync` falls stay queued, in order, for the next high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Queue can accept a command |
| cmd_data | input | 24 | Command word |
| vsync | input | 1 | Vertical sync, high enables draining |
| map_we | output | 1 | Map RAM write enable |
| map_addr | output | 9 | Map RAM write address |
| map_data | output | 14 | Map RAM write data |
| fifo_empty | output | 1 | Queue is empty |
| fifo_full | output | 1 | Queue is full |
| fifo_used | output | 9 | Number of queued commands |
| map_updated | output | 1 | One-cycle pulse after a vsync phase that wrote the map |

## Verification
The hardest case to reach from the ports is a queue that sits at its 300-entry limit while draining and refilling at the same time. Offers must be refused there, and `cmd_ready` must come back only after a pop. The stimulus holds `cmd_valid` high with vsync low until the queue fills and stays full. It then raises vsync for a short window while it keeps offering commands, which forces simultaneous push and pop at the boundary. The short window also leaves leftovers that must wait for the next phase. A separate vsync phase carries only off-screen commands. In that phase entries are consumed but nothing is written, so no update pulse may appear.

// File: rtl/symmap_pkg.sv
package symmap_pkg;
  localparam int ROWS   = 15;
  localparam int COLS   = 20;
  localparam int SYM_W  = 14;
  localparam int X_W    = $clog2(ROWS);
  localparam int Y_W    = $clog2(COLS);
  localparam int CMD_W  = 1 + SYM_W + X_W + Y_W;
  localparam int TILES  = ROWS * COLS;
  localparam int MAP_AW = $clog2(TILES);

  typedef struct packed {
    logic             add;
    logic [SYM_W-1:0] sym;
    logic [X_W-1:0]   x;
    logic [Y_W-1:0]   y;
  } tile_cmd_t;
endpackage

// File: rtl/symmap_cmd_fifo.sv
module symmap_cmd_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 300,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic [CW-1:0] used
);
  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout  = store[rd_ptr];
  assign used  = count;
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push == pop) |=> $stable(used)); // R3
  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full); // R2
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop); // R5
endmodule

// File: rtl/symmap_decode.sv
module symmap_decode
  import symmap_pkg::*;
(
  input  logic [CMD_W-1:0]  cmd,
  output logic              tile_ok,
  output logic [MAP_AW-1:0] idx,
  output logic [SYM_W-1:0]  wdata
);
  tile_cmd_t c;

  always_comb begin
    c       = tile_cmd_t'(cmd);
    tile_ok = (32'(c.x) < ROWS) && (32'(c.y) < COLS);
    idx     = MAP_AW'(c.x) * MAP_AW'(COLS) + MAP_AW'(c.y);
    wdata   = c.add ? c.sym : '0;
  end
endmodule

// File: rtl/symmap_sync_ctrl.sv
module symmap_sync_ctrl
  import symmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync,
  input  logic              fifo_empty,
  input  logic              tile_ok,
  input  logic [MAP_AW-1:0] idx,
  input  logic [SYM_W-1:0]  wdata,
  output logic              pop,
  output logic              map_we,
  output logic [MAP_AW-1:0] map_addr,
  output logic [SYM_W-1:0]  map_data,
  output logic              map_updated
);
  logic vs_q;
  logic applied;
  logic fall;

  assign pop  = vsync & ~fifo_empty;
  assign fall = vs_q & ~vsync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_q        <= 1'b0;
      applied     <= 1'b0;
      map_we      <= 1'b0;
      map_addr    <= '0;
      map_data    <= '0;
      map_updated <= 1'b0;
    end else begin
      vs_q        <= vsync;
      map_we      <= pop & tile_ok;
      map_updated <= fall & applied;
      if (pop) begin
        map_addr <= idx;
        map_data <= wdata;
      end
      if (fall)                applied <= 1'b0;
      else if (pop && tile_ok) applied <= 1'b1;
    end
  end

  AST_WRITE_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    map_we |-> vs_q); // R4
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    map_we |-> (32'(map_addr) < TILES)); // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    map_updated |=> !map_updated); // R9
  AST_PULSE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    map_updated |-> !map_we); // R9
endmodule

// File: rtl/symmap_updater.sv
module symmap_updater
  import symmap_pkg::*;
#(
  parameter int QDEPTH = TILES,
  localparam int UW    = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic              vsync,
  output logic              map_we,
  output logic [MAP_AW-1:0] map_addr,
  output logic [SYM_W-1:0]  map_data,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic [UW-1:0]     fifo_used,
  output logic              map_updated
);
  logic              push, pop;
  logic [CMD_W-1:0]  head;
  logic              tile_ok;
  logic [MAP_AW-1:0] idx;
  logic [SYM_W-1:0]  wdata;

  assign cmd_ready = ~fifo_full;
  assign push      = cmd_valid & cmd_ready;

  symmap_cmd_fifo #(.W(CMD_W), .DEPTH(QDEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(cmd_data), .pop(pop),
    .dout(head), .empty(fifo_empty), .full(fifo_full), .used(fifo_used)
  );

  symmap_decode u_dec (
    .cmd(head), .tile_ok(tile_ok), .idx(idx), .wdata(wdata)
  );

  symmap_sync_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .fifo_empty(fifo_empty),
    .tile_ok(tile_ok), .idx(idx), .wdata(wdata), .pop(pop),
    .map_we(map_we), .map_addr(map_addr), .map_data(map_data),
    .map_updated(map_updated)
  );

  AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !cmd_ready); // R2
endmodule

// File: tb/sim_symmap_updater.sv
module sim_symmap_updater;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [23:0] cmd_data = '0;
  logic vsync = 1'b0;
  logic cmd_ready, map_we, fifo_empty, fifo_full, map_updated;
  logic [8:0] map_addr, fifo_used;
  logic [13:0] map_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  symmap_updater u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .vsync(vsync), .map_we(map_we), .map_addr(map_addr),
    .map_data(map_data), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .fifo_used(fifo_used), .map_updated(map_updated)
  );

  // behavioural reference
  logic [23:0] q[$];
  bit e_we, e_upd, vs_prev, touched;
  int e_addr, e_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); e_we = 0; e_upd = 0; vs_prev = 0; touched = 0;
      e_addr = 0; e_data = 0;
    end else begin
      bit do_push, do_pop;
      logic [23:0] c;
      int x, y;
      do_push = cmd_valid && (q.size() < DEPTH);
      do_pop  = vsync && (q.size() > 0);
      e_we = 0;
      if (do_pop) begin
        c = q.pop_front();
        x = int'(c[8:5]); y = int'(c[4:0]);
        if (x <= 14 && y <= 19) begin
          e_we = 1; e_addr = 20*x + y;
          e_data = c[23] ? int'(c[22:9]) : 0;
        end
      end
      if (do_push) q.push_back(cmd_data);
      e_upd = vs_prev && !vsync && touched;
      if (vs_prev && !vsync) touched = 0;
      else if (e_we) touched = 1;
      vs_prev = vsync;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(map_we == e_we, "R5 map_we", int'(map_we), int'(e_we));
      if (e_we) begin
        chk(int'(map_addr) == e_addr, "R6 map_addr", int'(map_addr), e_addr);
        chk(int'(map_data) == e_data, "R7 map_data", int'(map_data), e_data);
      end
      chk(map_updated == e_upd, "R9 map_updated", int'(map_updated), int'(e_upd));
      chk(int'(fifo_used) == q.size(), "R3 fifo_used", int'(fifo_used), q.size());
      chk(fifo_empty == (q.size() == 0), "R3 fifo_empty", int'(fifo_empty), int'(q.size() == 0));
      chk(fifo_full == (q.size() == DEPTH), "R3 fifo_full", int'(fifo_full), int'(q.size() == DEPTH));
      chk(cmd_ready == (q.size() < DEPTH), "R2 cmd_ready", int'(cmd_ready), int'(q.size() < DEPTH));
    end
  end

  function automatic logic [23:0] mk(input bit add, input int sym, input int x, input int y);
    return {add, 14'(sym), 4'(x), 5'(y)};
  endfunction

  task automatic step(input bit v, input logic [23:0] d, input bit vs);
    @(negedge clk);
    cmd_valid = v; cmd_data = d; vsync = vs;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  int writes_seen = 0;
  int pulses_seen = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (map_we) writes_seen++;
      if (map_updated) pulses_seen++;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!map_we && !map_updated, "R1 outputs idle", int'(map_we | map_updated), 0);
    chk(fifo_empty && !fifo_full && fifo_used == 0 && cmd_ready, "R1 queue status",
        int'(fifo_used), 0);
    rst_n = 1'b1;

    // R4: queue commands with vsync low, nothing written
    step(1, mk(1, 100, 0, 0), 0);
    step(1, mk(1, 200, 14, 19), 0);
    step(1, mk(0, 555, 3, 7), 0);
    step(1, mk(1, 16383, 7, 10), 0);
    step(1, mk(1, 42, 1, 0), 0);
    step(0, '0, 0);
    repeat (5) step(0, '0, 0);
    chk(writes_seen == 0, "R4 no write while vsync low", writes_seen, 0);

    // R5/R6/R7 drain, R9 pulse
    repeat (8) step(0, '0, 1);
    repeat (4) step(0, '0, 0);
    chk(pulses_seen == 1, "R9 one pulse after drain", pulses_seen, 1);

    // R8: off-screen only, no pulse
    step(1, mk(1, 9, 15, 0), 0);
    step(1, mk(1, 9, 0, 20), 0);
    step(1, mk(1, 9, 15, 31), 0);
    step(0, '0, 0);
    writes_seen = 0;
    repeat (5) step(0, '0, 1);
    repeat (4) step(0, '0, 0);
    chk(writes_seen == 0, "R8 off-screen commands not written", writes_seen, 0);
    chk(pulses_seen == 1, "R9 no pulse without write", pulses_seen, 1);
    chk(fifo_empty == 1, "R8 off-screen commands consumed", int'(fifo_empty), 1);

    // R2/R3 fill past capacity
    for (int i = 0; i < DEPTH + 6; i++)
      step(1, mk(i[0], i * 3, i % 16, (i * 7) % 21), 0);
    step(0, '0, 0);
    chk(fifo_full && !cmd_ready, "R2 full refuses", int'(fifo_used), DEPTH);

    // push and pop at the full boundary, short vsync
    for (int i = 0; i < 10; i++) step(1, mk(1, 777 + i, 2, i), 1);
    repeat (3) step(0, '0, 0);
    chk(int'(fifo_used) == DEPTH - 1, "R10 leftovers kept", int'(fifo_used), DEPTH - 1);
    repeat (5) step(0, '0, 0);
    chk(int'(fifo_used) == DEPTH - 1, "R10 no drain between phases", int'(fifo_used), DEPTH - 1);

    // drain everything
    repeat (DEPTH + 5) step(0, '0, 1);
    repeat (4) step(0, '0, 0);
    chk(fifo_empty == 1, "R5 fully drained", int'(fifo_used), 0);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule